// File: doc/BRIEF.md
# SDRAM Bank Access Sequencer

This block drives a single SDRAM bank. A dispatcher hands it one access at a time: read or write, a row and a column. The block remembers which row of its bank is open. From that it works out the command sequence the access needs. If the row is already open, only the column command is sent. If the bank is closed, the row is opened first. If a different row is open, that row is closed, the new one is opened, and then the column command follows. Each command is raised as a request toward a shared-bus issuer and held until that issuer grants it.

Every wait between commands happens in one countdown state. On each grant, a down-counter is loaded from a small timing table and a code is stored that names what follows the wait: open a row, send the column command, or finish. Because of this, the precharge time, the activate-to-column time and the burst length can be changed at initialisation without touching the state machine. While the sequencer is busy, the dispatcher sees it as not ready. A new access is taken only once the previous one has fully completed.

Top module: `bank_seq_ctrl`

## Requirements
- R1: After reset the block is ready (`acc_ready`=1), raises no command request (`cmd_req`=0, `cmd_op`=0), and reports no open row (`row_open`=0).
- R2: An access to a bank with no open row produces ACTIVATE (`cmd_op`=1) and then the column command, with no PRECHARGE. The column command is READ (`cmd_op`=2) when `acc_write`=0 and WRITE (`cmd_op`=3) when `acc_write`=1.
- R3: An access whose row equals the open row produces only the column command, and this request appears in the cycle right after the access is accepted.
- R4: An access to a different row while a row is open produces PRECHARGE (`cmd_op`=4), then ACTIVATE, then the column command.
- R5: After a PRECHARGE is granted, the block spends exactly tRP cycles (at least 1) with its request low before it requests ACTIVATE.
- R6: After an ACTIVATE is granted, the block spends exactly tRCD cycles (at least 1) with its request low before it requests the column command.
- R7: After a column command is granted, `acc_ready` rises exactly BL cycles later. The burst field codes 0, 1, 2 and 3 select a BL of 1, 2, 4 and 8.
- R8: A request stays high with an unchanged opcode and address for as long as `cmd_grant` is low. No countdown starts before the grant.
- R9: `acc_ready` is low from the cycle after an access is accepted until that access completes. `acc_valid` pulsed while the block is busy is ignored and never starts a later command.
- R10: ACTIVATE carries the access row on `cmd_row`. READ and WRITE carry the access column on `cmd_col`.
- R11: `row_open` and `open_row` are updated on a granted ACTIVATE (open, with the access row), cleared on a granted PRECHARGE, and otherwise kept.
- R12: Pulsing `cfg_load` stores the tRP, tRCD and burst fields, which set the waits of every later access. The reset values are tRP=2, tRCD=2 and a burst field of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Store the timing fields |
| cfg_trp | input | 4 | Precharge wait, in cycles |
| cfg_trcd | input | 4 | Activate-to-column wait, in cycles |
| cfg_burst | input | 2 | Burst length code (BL = 2^code) |
| acc_valid | input | 1 | Access offered by dispatcher |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_row | input | 13 | Access row |
| acc_col | input | 10 | Access column |
| acc_ready | output | 1 | Sequencer idle, access accepted when valid |
| cmd_req | output | 1 | Command request to the bus issuer |
| cmd_op | output | 3 | 0 none, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmd_row | output | 13 | Row of the current access |
| cmd_col | output | 10 | Column of the current access |
| cmd_grant | input | 1 | Issuer accepts the request this cycle |
| row_open | output | 1 | A row of this bank is open |
| open_row | output | 13 | The open row |

## Verification
The assertions rely on a few things about the inputs. The issuer grants only while a request is raised. Timing fields change only while the block is idle. tRP and tRCD are loaded as nonzero values. The stimulus respects all of these: grants are driven only after a request is seen, configuration is loaded between accesses, and the sweep covers tRP and tRCD from 1 to 3 together with every burst code. Grants are delayed by zero, one or two cycles, and one busy-time `acc_valid` pulse is injected to confirm it is ignored.

// File: rtl/bank_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types for the bank sequencer: bus opcodes, FSM states and
// the code that names the step following a countdown.
package bank_ctrl_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WAIT = 2'd2
    } bank_state_e;

    typedef enum logic [1:0] {
        NXT_ACT  = 2'd0,
        NXT_RW   = 2'd1,
        NXT_DONE = 2'd2
    } nop_code_e;
endpackage

// File: rtl/bank_timing_regs.sv
`timescale 1ns/1ps
// Timing table: holds tRP, tRCD and the burst code written at setup and
// presents each as a countdown preload (value minus one).
// Assumes cfg_load is pulsed only while the sequencer is idle.
module bank_timing_regs #(
    parameter int TW        = 4,
    parameter int DEF_TRP   = 2,
    parameter int DEF_TRCD  = 2,
    parameter int DEF_BURST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [TW-1:0] cfg_trp,
    input  logic [TW-1:0] cfg_trcd,
    input  logic [1:0]    cfg_burst,
    output logic [TW-1:0] wait_trp,
    output logic [TW-1:0] wait_trcd,
    output logic [TW-1:0] wait_burst
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] trp_q;
    logic [TW-1:0] trcd_q;
    logic [1:0]    burst_q;

    // Store the timing fields on a load pulse, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trp_q   <= TW'(DEF_TRP);
            trcd_q  <= TW'(DEF_TRCD);
            burst_q <= 2'(DEF_BURST);
        end else if (cfg_load) begin
            trp_q   <= cfg_trp;
            trcd_q  <= cfg_trcd;
            burst_q <= cfg_burst;
        end
    end

    // Convert stored cycles to countdown preloads; a zero field acts as one.
    always_comb begin
        wait_trp   = (trp_q  == '0) ? '0 : trp_q  - ONE;
        wait_trcd  = (trcd_q == '0) ? '0 : trcd_q - ONE;
        wait_burst = (ONE << burst_q) - ONE;
    end
endmodule

// File: rtl/bank_row_tracker.sv
`timescale 1ns/1ps
// Open-row register of one bank plus the hit comparison against an
// incoming row. Assumes at most one of act_fire/pre_fire per cycle.
module bank_row_tracker #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] act_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row,
    output logic             row_hit
);
    // Record the activated row; forget it on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (act_fire) begin
            row_open <= 1'b1;
            open_row <= act_row;
        end else if (pre_fire) begin
            row_open <= 1'b0;
        end
    end

    // Hit when the bank is open on the compared row.
    assign row_hit = row_open && (open_row == cmp_row);

    a_r11_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> row_open && (open_row == $past(act_row)));
    a_r11_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |=> !row_open);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !act_fire && !pre_fire |=> $stable(row_open) && $stable(open_row));
endmodule

// File: rtl/bank_access_fsm.sv
`timescale 1ns/1ps
// Access state machine: idle, request a command, or count down in one
// shared wait state whose code names the following step.
// Assumes cmd_grant is asserted only while cmd_req is high.
module bank_access_fsm
    import bank_ctrl_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int TW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    input  logic             row_open,
    input  logic             row_hit,
    input  logic [TW-1:0]    wait_trp,
    input  logic [TW-1:0]    wait_trcd,
    input  logic [TW-1:0]    wait_burst,
    input  logic             cmd_grant,
    output logic             acc_ready,
    output logic             cmd_req,
    output logic [2:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             act_fire,
    output logic             pre_fire
);
    bank_state_e      state_q;
    sdram_cmd_e       cmd_q;
    nop_code_e        code_q;
    logic [TW-1:0]    cnt_q;
    logic             wr_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             fire;

    assign fire = (state_q == ST_CMD) && cmd_grant;

    // Sequence one access: choose first command, load waits on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            code_q  <= NXT_DONE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        wr_q    <= acc_write;
                        row_q   <= acc_row;
                        col_q   <= acc_col;
                        state_q <= ST_CMD;
                        if (row_hit)       cmd_q <= acc_write ? CMD_WR : CMD_RD;
                        else if (row_open) cmd_q <= CMD_PRE;
                        else               cmd_q <= CMD_ACT;
                    end
                end
                ST_CMD: begin
                    if (cmd_grant) begin
                        state_q <= ST_WAIT;
                        unique case (cmd_q)
                            CMD_PRE: begin cnt_q <= wait_trp;   code_q <= NXT_ACT;  end
                            CMD_ACT: begin cnt_q <= wait_trcd;  code_q <= NXT_RW;   end
                            default: begin cnt_q <= wait_burst; code_q <= NXT_DONE; end
                        endcase
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        unique case (code_q)
                            NXT_ACT: begin cmd_q <= CMD_ACT; state_q <= ST_CMD; end
                            NXT_RW: begin
                                cmd_q   <= wr_q ? CMD_WR : CMD_RD;
                                state_q <= ST_CMD;
                            end
                            default: begin cmd_q <= CMD_NOP; state_q <= ST_IDLE; end
                        endcase
                    end else begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
            endcase
        end
    end

    // Drive the request side and the row-tracker strobes.
    always_comb begin
        acc_ready = (state_q == ST_IDLE);
        cmd_req   = (state_q == ST_CMD);
        cmd_op    = cmd_req ? cmd_q : CMD_NOP;
        cmd_row   = row_q;
        cmd_col   = col_q;
        act_fire  = fire && (cmd_q == CMD_ACT);
        pre_fire  = fire && (cmd_q == CMD_PRE);
    end

    a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_grant |=> cmd_req && $stable(cmd_op) && $stable(cmd_row) && $stable(cmd_col));
    a_r5_gap_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_grant |=> !cmd_req);
    a_r7_burst_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_grant && (cmd_op == 3'd2 || cmd_op == 3'd3) |=> !acc_ready);
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready && acc_valid |=> !acc_ready && cmd_req);
endmodule

// File: rtl/bank_seq_ctrl.sv
`timescale 1ns/1ps
// Top of the per-bank sequencer: timing table, open-row tracker and
// access FSM. Assumes one issuer grants requests of this bank and that
// the timing table is loaded only between accesses.
module bank_seq_ctrl
    import bank_ctrl_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int TW        = 4,
    parameter int DEF_TRP   = 2,
    parameter int DEF_TRCD  = 2,
    parameter int DEF_BURST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic [1:0]       cfg_burst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    output logic             acc_ready,
    output logic             cmd_req,
    output logic [2:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    input  logic             cmd_grant,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row
);
    logic [TW-1:0] wait_trp;
    logic [TW-1:0] wait_trcd;
    logic [TW-1:0] wait_burst;
    logic          row_hit;
    logic          act_fire;
    logic          pre_fire;

    bank_timing_regs #(
        .TW(TW), .DEF_TRP(DEF_TRP), .DEF_TRCD(DEF_TRCD), .DEF_BURST(DEF_BURST)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_burst(cfg_burst),
        .wait_trp(wait_trp), .wait_trcd(wait_trcd), .wait_burst(wait_burst)
    );

    bank_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .pre_fire(pre_fire),
        .act_row(cmd_row), .cmp_row(acc_row),
        .row_open(row_open), .open_row(open_row), .row_hit(row_hit)
    );

    bank_access_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_row(acc_row), .acc_col(acc_col),
        .row_open(row_open), .row_hit(row_hit),
        .wait_trp(wait_trp), .wait_trcd(wait_trcd), .wait_burst(wait_burst),
        .cmd_grant(cmd_grant),
        .acc_ready(acc_ready), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col),
        .act_fire(act_fire), .pre_fire(pre_fire)
    );

    a_r3_column_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && (cmd_op == 3'd2 || cmd_op == 3'd3) |-> row_open && (open_row == cmd_row));
    a_r2_act_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && (cmd_op == 3'd1) |-> !row_open);
    a_r4_pre_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && (cmd_op == 3'd4) |-> row_open);
endmodule

// File: tb/tb_bank_seq_ctrl.sv
`timescale 1ns/1ps
module tb_bank_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [3:0]  cfg_trp = '0;
    logic [3:0]  cfg_trcd = '0;
    logic [1:0]  cfg_burst = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [12:0] acc_row = '0;
    logic [9:0]  acc_col = '0;
    logic        acc_ready;
    logic        cmd_req;
    logic [2:0]  cmd_op;
    logic [12:0] cmd_row;
    logic [9:0]  cmd_col;
    logic        cmd_grant = 1'b0;
    logic        row_open;
    logic [12:0] open_row;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit m_open = 0;
    logic [12:0] m_row = '0;

    bank_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_trp(cfg_trp),
        .cfg_trcd(cfg_trcd), .cfg_burst(cfg_burst), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_row(acc_row), .acc_col(acc_col),
        .acc_ready(acc_ready), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_grant(cmd_grant),
        .row_open(row_open), .open_row(open_row)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
        finish_run();
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic load_cfg(input int trp, input int trcd, input int bc);
        @(negedge clk);
        cfg_trp = 4'(trp); cfg_trcd = 4'(trcd); cfg_burst = 2'(bc); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // One access: compute expected sequence from the model, grant each
    // command after gdly cycles, and check opcodes, addresses and gaps.
    task automatic run_access(input bit wr, input logic [12:0] row, input logic [9:0] col,
                              input int trp, input int trcd, input int bl,
                              input int gdly, input bit poke);
        int ops[3];
        int nops;
        int a, g, expc;
        int rwop;
        rwop = wr ? 3 : 2;
        if (m_open && m_row == row) begin ops[0] = rwop; nops = 1; end
        else if (m_open) begin ops[0] = 4; ops[1] = 1; ops[2] = rwop; nops = 3; end
        else begin ops[0] = 1; ops[1] = rwop; nops = 2; end
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_row = row; acc_col = col;
        @(negedge clk);
        acc_valid = 1'b0;
        a = cyc;
        chk(!acc_ready, "R9 ready drops after accept", int'(acc_ready), 0);
        g = a;
        for (int i = 0; i < nops; i++) begin
            if (i == 0) expc = a;
            else if (ops[i-1] == 4) expc = g + trp;
            else expc = g + trcd;
            while (!cmd_req) @(negedge clk);
            if (ops[i] == 4) chk(cyc == expc, "R4 R5 request cycle", cyc, expc);
            else if (ops[i] == 1) chk(cyc == expc, "R6 R12 request cycle", cyc, expc);
            else chk(cyc == expc, "R3 R6 request cycle", cyc, expc);
            if (nops == 1) chk(int'(cmd_op) == ops[i], "R3 hit opcode", int'(cmd_op), ops[i]);
            else if (nops == 2) chk(int'(cmd_op) == ops[i], "R2 closed-bank opcode", int'(cmd_op), ops[i]);
            else chk(int'(cmd_op) == ops[i], "R4 miss opcode", int'(cmd_op), ops[i]);
            if (ops[i] == 1) chk(cmd_row == row, "R10 activate row", int'(cmd_row), int'(row));
            if (ops[i] == 2 || ops[i] == 3) chk(cmd_col == col, "R10 column", int'(cmd_col), int'(col));
            for (int d = 0; d < gdly; d++) begin
                if (poke && d == 0) begin
                    acc_valid = 1'b1; acc_row = row ^ 13'h1555; acc_write = ~wr;
                end
                @(negedge clk);
                acc_valid = 1'b0;
                chk(cmd_req && int'(cmd_op) == ops[i], "R8 request held", int'(cmd_op), ops[i]);
            end
            cmd_grant = 1'b1;
            @(negedge clk);
            cmd_grant = 1'b0;
            g = cyc;
            if (ops[i] == 4) m_open = 0;
            if (ops[i] == 1) begin m_open = 1; m_row = row; end
            chk(row_open == m_open, "R11 open flag", int'(row_open), int'(m_open));
            if (m_open) chk(open_row == m_row, "R11 open row", int'(open_row), int'(m_row));
        end
        while (!acc_ready) @(negedge clk);
        chk(cyc == g + bl, "R7 R12 burst return", cyc, g + bl);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!cmd_req && acc_ready, "R9 busy valid ignored", int'(cmd_req), 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(acc_ready == 1'b1, "R1 ready at reset", int'(acc_ready), 1);
        chk(cmd_req == 1'b0 && cmd_op == 3'd0, "R1 no request at reset", int'(cmd_op), 0);
        chk(row_open == 1'b0, "R1 no open row at reset", int'(row_open), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_ready && !cmd_req && !row_open, "R1 idle after reset", int'(cmd_req), 0);
        // Reset timing values: tRP 2, tRCD 2, BL 4.
        run_access(1'b0, 13'h0040, 10'h011, 2, 2, 4, 0, 1'b0);
        run_access(1'b1, 13'h0041, 10'h022, 2, 2, 4, 2, 1'b1);
        for (int bc = 0; bc < 4; bc++)
            for (int tp = 1; tp <= 3; tp++)
                for (int tc = 1; tc <= 3; tc++) begin
                    int k;
                    k = bc * 9 + (tp - 1) * 3 + (tc - 1);
                    load_cfg(tp, tc, bc);
                    run_access(k[0], 13'(100 + k), 10'(3 * k), tp, tc, 1 << bc, k % 3, 1'b0);
                    run_access(~k[0], 13'(100 + k), 10'(3 * k + 1), tp, tc, 1 << bc, (k + 1) % 3, 1'b0);
                    run_access(k[1], 13'(900 + k), 10'(7 * k), tp, tc, 1 << bc, (k + 2) % 3, 1'b0);
                end
        finish_run();
    end
endmodule